// File: doc/BRIEF.md
# Keyed Service Watchdog

This block is a watchdog counter that cannot be switched off. It starts counting as soon as reset is released. Software must keep restarting it before a fixed number of clock cycles has passed. If software fails to do so, the block raises a one-cycle reset request to the chip's reset controller. The controller then stretches the request into a full system reset, which in turn clears this block.

Software restarts the count by writing one exact key byte to one write-only location on a simple write bus. A write of any other value to that location is ignored. A write of the key to any other location is also ignored, as is the key placed on the bus without the write strobe. The timeout length is a parameter counted in clock cycles. A simulation can therefore run with a short interval, while silicon uses the long one (about 700000 cycles at 4 MHz).

After the request fires, the block stops counting and ignores all writes until the next reset.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_ni` is low, `rst_req_o` is low and the count is cleared. After release the watchdog runs with no enable step of any kind.
- R2: If no valid service write occurs after reset release, `rst_req_o` is high during exactly the cycle that follows rising edge number TIMEOUT_CYCLES after release.
- R3: A service write restarts the count. A service write is `wr_en_i` high, `addr_i` equal to KEY_ADDR (default 0x0A) and `wdata_i` equal to KEY_VAL (default 0x55), all sampled at one rising edge. The request then follows rising edge number TIMEOUT_CYCLES after that edge.
- R4: A write to KEY_ADDR with any data other than KEY_VAL is ignored. It does not restart the count.
- R5: A write of KEY_VAL to any address other than KEY_ADDR is ignored. This includes addresses that differ only in the top bit.
- R6: The request lasts one cycle. After it the block is halted: it makes no further request, and service writes have no effect, until reset.
- R7: A service write sampled at the same edge on which the count would expire restarts the count, and no request is issued at that edge.
- R8: Service writes repeated at intervals shorter than the timeout keep `rst_req_o` low indefinitely.
- R9: KEY_VAL at KEY_ADDR with `wr_en_i` low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Bus write address |
| wdata_i | input | DATA_W | Bus write data |
| rst_req_o | output | 1 | One-cycle reset request to the reset controller |

## Verification
The hardest case to reach is a service write that lands on exactly the edge where the count expires. At that edge the restart and the expiry compete, and a slip of one cycle either way tests a different path. The bench reaches this case by releasing reset at a known negative edge, counting edges from there, and placing the key write one cycle before the expiry edge, on it, and one cycle after it. The case one cycle after expiry must show that a halted block stays halted.

// File: rtl/svc_wdt_pkg.sv
package svc_wdt_pkg;
  typedef enum logic {
    WDT_RUN  = 1'b0,
    WDT_HALT = 1'b1
  } wdt_state_e;

  localparam logic [7:0] WDT_KEY_DEFAULT  = 8'h55;
  localparam logic [7:0] WDT_ADDR_DEFAULT = 8'h0A;
endpackage

// File: rtl/svc_wdt_key_match.sv
module svc_wdt_key_match #(
  parameter int unsigned           ADDR_W   = 8,
  parameter int unsigned           DATA_W   = 8,
  parameter logic [ADDR_W-1:0]     KEY_ADDR = 8'h0A,
  parameter logic [DATA_W-1:0]     KEY_VAL  = 8'h55
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              kick_o
);
  logic addr_hit;
  logic data_hit;

  assign addr_hit = (addr_i == KEY_ADDR);
  assign data_hit = (wdata_i == KEY_VAL);
  assign kick_o   = wr_en_i & addr_hit & data_hit;
endmodule

// File: rtl/svc_wdt_counter.sv
module svc_wdt_counter
  import svc_wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 700000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned       CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(TIMEOUT_CYCLES - 1);

  wdt_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last  = (cnt_q == LAST);
  assign expire_o = (state_q == WDT_RUN) && !kick_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WDT_RUN;
      cnt_q   <= '0;
    end else if (state_q == WDT_RUN) begin
      if (kick_i)       cnt_q   <= '0;
      else if (at_last) state_q <= WDT_HALT;
      else              cnt_q   <= cnt_q + 1'b1;
    end
  end

  // halted state is sticky until reset
  assert_halt_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WDT_HALT) |=> (state_q == WDT_HALT) && $stable(cnt_q));

  assert_kick_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && state_q == WDT_RUN) |=> (cnt_q == '0) && (state_q == WDT_RUN));

  assert_expire_only_running_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (state_q == WDT_HALT));
endmodule

// File: rtl/svc_wdt_req_pulse.sv
module svc_wdt_req_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  output logic rst_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_o <= 1'b0;
    else         rst_req_o <= expire_i;
  end

  assert_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wdt_pkg::*;
#(
  parameter int unsigned       TIMEOUT_CYCLES = 700000,
  parameter int unsigned       ADDR_W         = 8,
  parameter int unsigned       DATA_W         = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR       = ADDR_W'(WDT_ADDR_DEFAULT),
  parameter logic [DATA_W-1:0] KEY_VAL        = DATA_W'(WDT_KEY_DEFAULT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rst_req_o
);
  logic kick;
  logic expire;

  svc_wdt_key_match #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEY_ADDR(KEY_ADDR),
    .KEY_VAL (KEY_VAL)
  ) u_key (
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .kick_o (kick)
  );

  svc_wdt_counter #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kick_i  (kick),
    .expire_o(expire)
  );

  svc_wdt_req_pulse u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .rst_req_o(rst_req_o)
  );

  // a valid key always wins over expiry in the same cycle
  assert_key_suppresses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> !rst_req_o);

  assert_strobe_needed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> !kick);

  assert_wrong_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdata_i != KEY_VAL) |-> !kick);

  assert_wrong_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != KEY_ADDR) |-> !kick);
endmodule

// File: tb/svc_watchdog_tb.sv
module svc_watchdog_tb_top;
  localparam int T    = 16;
  localparam int NV   = 11;
  localparam int SPAN = 3 * T + 5;

  // {wait(8), wr(8), addr(8), data(8), expected request edge(8)}
  localparam logic [39:0] VEC [NV] = '{
    {8'd3,  8'd1, 8'h0A, 8'h55, 8'd20}, // R3
    {8'd3,  8'd1, 8'h0A, 8'hAA, 8'd16}, // R4
    {8'd5,  8'd1, 8'h0B, 8'h55, 8'd16}, // R5
    {8'd14, 8'd1, 8'h0A, 8'h55, 8'd31}, // R3 one before expiry
    {8'd15, 8'd1, 8'h0A, 8'h55, 8'd32}, // R7 on expiry edge
    {8'd16, 8'd1, 8'h0A, 8'h55, 8'd16}, // R6 after expiry
    {8'd0,  8'd1, 8'h0A, 8'h55, 8'd17}, // R3 first edge
    {8'd7,  8'd1, 8'h0A, 8'h54, 8'd16}, // R4
    {8'd7,  8'd1, 8'h8A, 8'h55, 8'd16}, // R5 top bit
    {8'd9,  8'd1, 8'h0A, 8'hD5, 8'd16}, // R4
    {8'd4,  8'd0, 8'h0A, 8'h55, 8'd16}  // R9
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       rst_req_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk_i = ~clk_i;

  svc_watchdog #(.TIMEOUT_CYCLES(T)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rst_req_o(rst_req_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 request low in reset", int'(rst_req_o), 0);
    rst_ni = 1'b1;
  endtask

  // walks SPAN edges after release; kick at edge kick_e (0 = none); returns first req edge and pulse count
  task automatic run(input int kick_e, input logic wr, input logic [7:0] a,
                     input logic [7:0] d, output int first, output int pulses);
    first  = 0;
    pulses = 0;
    do_reset();
    for (int e = 1; e <= SPAN; e++) begin
      wr_en_i = (e == kick_e) ? wr : 1'b0;
      addr_i  = a;
      wdata_i = d;
      @(posedge clk_i);
      @(negedge clk_i);
      if (rst_req_o) begin
        pulses++;
        if (first == 0) first = e;
      end
    end
    wr_en_i = 1'b0;
  endtask

  initial begin
    int first;
    int pulses;
    int last_kick;

    // R1 R2: untouched watchdog fires at edge T, once (R6)
    run(0, 1'b0, 8'h00, 8'h00, first, pulses);
    check("R2 request edge", first, T);
    check("R6 pulse count", pulses, 1);

    for (int i = 0; i < NV; i++) begin
      run(int'(VEC[i][39:32]) + 1, VEC[i][24], VEC[i][23:16], VEC[i][15:8], first, pulses);
      check($sformatf("vec%0d R3/R4/R5/R6/R7/R9 request edge", i), first, int'(VEC[i][7:0]));
      check($sformatf("vec%0d R6 pulse count", i), pulses, 1);
    end

    // R8: periodic servicing keeps request low, then stopping lets it fire
    do_reset();
    pulses    = 0;
    first     = 0;
    last_kick = 0;
    for (int e = 1; e <= 120 + T + 5; e++) begin
      wr_en_i = (e % (T - 3) == 0) && (e <= 120);
      addr_i  = 8'h0A;
      wdata_i = 8'h55;
      if (wr_en_i) last_kick = e;
      @(posedge clk_i);
      @(negedge clk_i);
      if (rst_req_o) begin
        pulses++;
        if (first == 0) first = e;
      end
    end
    wr_en_i = 1'b0;
    check("R8 request after service stops", first, last_kick + T);
    check("R8 pulse count", pulses, 1);

    // R1: reset mid-count restarts from zero
    do_reset();
    repeat (10) @(negedge clk_i);
    run(0, 1'b0, 8'h00, 8'h00, first, pulses);
    check("R1 restart after mid-count reset", first, T);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule